// File: doc/BRIEF.md
# Function Unit Dependency Matrix

This block keeps the hazard state between the function units of a scoreboarded out-of-order core. Arithmetic units and load/store units are treated alike. Each one owns a row and a column of a square array of single-bit wait cells. When an instruction is issued, it is bound to an idle unit. The issue carries two vectors naming the units whose results it must wait for: one for read-after-write and one for write-after-write. The matrix then sends each unit a one-cycle go-read grant when all its read-after-write waits are gone. Later it sends a one-cycle go-write (commit) grant when all its write-after-write waits are gone and the unit is not holding off its own write.

A unit may start executing after go-read and keep its result in its own buffer until go-write arrives. Precise exceptions come from a per-unit write-hold input, which the unit keeps high until it knows it cannot fault. Speculation is undone with a per-unit kill input, which frees the unit and wipes its row and column. When the ordering parameter is set, every unit that is busy at issue time is also entered as a write-after-write wait. Commits therefore happen in issue order, while reads and execution may still run ahead.

The issue port is valid/ready. An issue is taken on a clock edge where `issue_valid` and `issue_ready` are both high, and only one is taken per cycle. While `issue_ready` is low, the issuer must hold its request, and the request has no effect. The per-unit hold, kill and write-done lines are plain level inputs.

Top module: `fudm_matrix`

## Requirements
- R1: `issue_ready` is high only when `issue_unit` names a unit that is idle and is not being killed in that cycle. An issue taken on a clock edge makes that unit busy after the edge. An issue that is not ready changes no state.
- R2: After an issue is taken at clock edge e to a unit whose read-after-write waits are all clear, that unit's `go_rd` bit is high for exactly the one cycle after edge e+1.
- R3: While any unit named as a read-after-write producer is still busy, the consumer's `go_rd` stays low. If the producer retires at edge e, the consumer's `go_rd` rises after edge e+1.
- R4: `go_wr` for a unit is a one-cycle pulse. Its earliest edge is the one after the edge that raised that unit's `go_rd`, and it never comes in the same cycle as that unit's `go_rd`.
- R5: While a unit's `wr_hold` bit is high, no `go_wr` pulse is produced for that unit. When the hold is dropped, with no other waits, `go_wr` rises after the next edge.
- R6: With ORDERED set, the write-after-write row of a newly issued unit holds every unit that is busy at issue, in addition to the `issue_waw` vector. So a younger unit gets no `go_wr` until all older units have retired, and it gets it one edge after the last of them retires.
- R7: A `go_die` bit on a busy unit makes that unit idle after the next edge, with no `go_rd` or `go_wr` pulse on that edge. Its column is cleared in the same edge, so a consumer that waited on it gets `go_rd` one edge later.
- R8: `wr_done` retires a unit only after that unit has received `go_wr`. At any other time `wr_done` is ignored and the unit stays busy.
- R9: On issue, wait bits that name an idle unit, or name the unit being issued, are dropped.
- R10: After reset, all units are idle, `busy`, `go_rd` and `go_wr` are all zero, and `issue_ready` is high for any in-range unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue_valid | input | 1 | Issue request present |
| issue_ready | output | 1 | Issue target can accept |
| issue_unit | input | IW | Index of the unit receiving the instruction |
| issue_raw | input | N | Units whose write the new instruction must read after |
| issue_waw | input | N | Units whose write the new instruction must write after |
| wr_hold | input | N | Per-unit write prevention (exception not yet ruled out) |
| go_die | input | N | Per-unit kill of a wrongly speculated instruction |
| wr_done | input | N | Per-unit end of result write after go_wr |
| busy | output | N | Per-unit busy flags |
| go_rd | output | N | Per-unit one-cycle operand read grant |
| go_wr | output | N | Per-unit one-cycle commit grant |

## Verification
A wait cell that is set when it should be clear, or that fails to clear, shows up as a `go_rd` or `go_wr` pulse that is missing, or that arrives one or more cycles late against the retire edge of the producer. The bench checks each grant in the exact cycle it is due, so such an error is caught within two cycles of the edge that should have released it. A unit state that never returns to idle shows on `busy` and `issue_ready` one cycle after the `wr_done` or `go_die` edge. The bench sweeps every ordered producer/consumer pair of a four-unit matrix, so a fault in any single row or column is exposed.

// File: rtl/fudm_pkg.sv
package fudm_pkg;
  typedef enum logic [1:0] {
    U_IDLE    = 2'd0,
    U_WAIT_RD = 2'd1,
    U_EXEC    = 2'd2,
    U_COMMIT  = 2'd3
  } unit_st_e;
endpackage

// File: rtl/fudm_issue_dec.sv
module fudm_issue_dec #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic          issue_valid,
  input  logic [IW-1:0] issue_unit,
  input  logic [N-1:0]  busy,
  input  logic [N-1:0]  go_die,
  output logic          issue_ready,
  output logic [N-1:0]  load
);
  logic [N-1:0] hit;

  for (genvar i = 0; i < N; i++) begin : g_hit
    assign hit[i] = (issue_unit == IW'(i));
  end

  // ready: target exists, is idle and is not being killed this cycle
  assign issue_ready = (|hit) && !(|(hit & (busy | go_die)));
  assign load        = (issue_valid && issue_ready) ? hit : '0;
endmodule

// File: rtl/fudm_row.sv
module fudm_row #(
  parameter int N       = 8,
  parameter int ROW     = 0,
  parameter bit ORDERED = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         row_kill,
  input  logic [N-1:0] raw_in,
  input  logic [N-1:0] waw_in,
  input  logic [N-1:0] busy_vec,
  input  logic [N-1:0] col_clr,
  output logic         raw_pend,
  output logic         waw_pend
);
  localparam logic [N-1:0] SELF = N'(1) << ROW;
  localparam logic [N-1:0] ORD  = ORDERED ? '1 : '0;

  logic [N-1:0] raw_q, waw_q, raw_nx, waw_nx, live;

  // a wait may only name a unit that is busy now and not leaving this edge
  assign live = busy_vec & ~col_clr & ~SELF;

  always_comb begin
    if (row_kill) begin
      raw_nx = '0;
      waw_nx = '0;
    end else if (load) begin
      raw_nx = raw_in & live;
      waw_nx = (waw_in | ORD) & live;
    end else begin
      raw_nx = raw_q & ~col_clr;
      waw_nx = waw_q & ~col_clr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= '0;
      waw_q <= '0;
    end else begin
      raw_q <= raw_nx;
      waw_q <= waw_nx;
    end
  end

  assign raw_pend = |raw_q;
  assign waw_pend = |waw_q;
endmodule

// File: rtl/fudm_unit_ctl.sv
module fudm_unit_ctl
  import fudm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic die,
  input  logic wr_done,
  input  logic hold,
  input  logic raw_pend,
  input  logic waw_pend,
  output logic busy,
  output logic go_rd,
  output logic go_wr,
  output logic retire
);
  unit_st_e st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= U_IDLE;
      go_rd <= 1'b0;
      go_wr <= 1'b0;
    end else begin
      go_rd <= 1'b0;
      go_wr <= 1'b0;
      if (die) begin
        st_q <= U_IDLE;
      end else begin
        unique case (st_q)
          U_IDLE:    if (load) st_q <= U_WAIT_RD;
          U_WAIT_RD: if (!raw_pend) begin
                       go_rd <= 1'b1;
                       st_q  <= U_EXEC;
                     end
          U_EXEC:    if (!waw_pend && !hold) begin
                       go_wr <= 1'b1;
                       st_q  <= U_COMMIT;
                     end
          U_COMMIT:  if (wr_done) st_q <= U_IDLE;
          default:   st_q <= U_IDLE;
        endcase
      end
    end
  end

  assign busy   = (st_q != U_IDLE);
  assign retire = (st_q == U_COMMIT && wr_done) || (die && st_q != U_IDLE);
endmodule

// File: rtl/fudm_matrix.sv
module fudm_matrix #(
  parameter int N       = 8,
  parameter bit ORDERED = 1'b1,
  localparam int IW     = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue_valid,
  output logic          issue_ready,
  input  logic [IW-1:0] issue_unit,
  input  logic [N-1:0]  issue_raw,
  input  logic [N-1:0]  issue_waw,
  input  logic [N-1:0]  wr_hold,
  input  logic [N-1:0]  go_die,
  input  logic [N-1:0]  wr_done,
  output logic [N-1:0]  busy,
  output logic [N-1:0]  go_rd,
  output logic [N-1:0]  go_wr
);
  logic [N-1:0] load, retire, raw_pend, waw_pend, kill;

  fudm_issue_dec #(.N(N), .IW(IW)) u_dec (
    .issue_valid (issue_valid),
    .issue_unit  (issue_unit),
    .busy        (busy),
    .go_die      (go_die),
    .issue_ready (issue_ready),
    .load        (load)
  );

  assign kill = go_die & busy;

  for (genvar i = 0; i < N; i++) begin : g_unit
    fudm_row #(.N(N), .ROW(i), .ORDERED(ORDERED)) u_row (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load[i]),
      .row_kill (kill[i]),
      .raw_in   (issue_raw),
      .waw_in   (issue_waw),
      .busy_vec (busy),
      .col_clr  (retire),
      .raw_pend (raw_pend[i]),
      .waw_pend (waw_pend[i])
    );

    fudm_unit_ctl u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load[i]),
      .die      (go_die[i]),
      .wr_done  (wr_done[i]),
      .hold     (wr_hold[i]),
      .raw_pend (raw_pend[i]),
      .waw_pend (waw_pend[i]),
      .busy     (busy[i]),
      .go_rd    (go_rd[i]),
      .go_wr    (go_wr[i]),
      .retire   (retire[i])
    );
  end
endmodule

// File: rtl/fudm_matrix_chk.sv
module fudm_matrix_chk #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          issue_valid,
  input logic          issue_ready,
  input logic [IW-1:0] issue_unit,
  input logic [N-1:0]  wr_hold,
  input logic [N-1:0]  go_die,
  input logic [N-1:0]  busy,
  input logic [N-1:0]  go_rd,
  input logic [N-1:0]  go_wr
);
  a_r1_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && issue_ready) |=> busy[$past(issue_unit)]);

  for (genvar i = 0; i < N; i++) begin : g_chk
    a_r2_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
      go_rd[i] |=> !go_rd[i]);
    a_r4_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
      go_wr[i] |=> !go_wr[i]);
    a_r4_not_both: assert property (@(posedge clk) disable iff (!rst_n)
      go_rd[i] |-> !go_wr[i]);
    a_r5_hold_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hold[i] |=> !go_wr[i]);
    a_r7_die_idle: assert property (@(posedge clk) disable iff (!rst_n)
      go_die[i] |=> (!busy[i] && !go_rd[i] && !go_wr[i]));
  end
endmodule

bind fudm_matrix fudm_matrix_chk #(.N(N), .IW(IW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .issue_valid (issue_valid),
  .issue_ready (issue_ready),
  .issue_unit  (issue_unit),
  .wr_hold     (wr_hold),
  .go_die      (go_die),
  .busy        (busy),
  .go_rd       (go_rd),
  .go_wr       (go_wr)
);

// File: tb/tb_fudm_matrix.sv
module tb_fudm_matrix;
  localparam int N  = 4;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          issue_valid = 1'b0;
  logic          issue_ready;
  logic [IW-1:0] issue_unit = '0;
  logic [N-1:0]  issue_raw = '0, issue_waw = '0;
  logic [N-1:0]  wr_hold = '0, go_die = '0, wr_done = '0;
  logic [N-1:0]  busy, go_rd, go_wr;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  fudm_matrix #(.N(N), .ORDERED(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_ready(issue_ready),
    .issue_unit(issue_unit), .issue_raw(issue_raw), .issue_waw(issue_waw),
    .wr_hold(wr_hold), .go_die(go_die), .wr_done(wr_done),
    .busy(busy), .go_rd(go_rd), .go_wr(go_wr)
  );

  function automatic logic [N-1:0] oh(input int u);
    return N'(1) << u;
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive an issue for one cycle; returns at the negedge after the taking edge
  task automatic issue(input int u, input logic [N-1:0] raw, input logic [N-1:0] waw);
    issue_valid = 1'b1;
    issue_unit  = IW'(u);
    issue_raw   = raw;
    issue_waw   = waw;
    step();
    issue_valid = 1'b0;
    issue_raw   = '0;
    issue_waw   = '0;
  endtask

  task automatic finish_unit(input int u);
    wr_hold[u] = 1'b0;
    for (int k = 0; k < 20; k++) begin
      if (go_wr[u]) break;
      step();
    end
    wr_done = oh(u);
    step();
    wr_done = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    step();
    step();
    rst_n = 1'b1;
    step();
    // R10 reset state
    chk("R10 busy", 32'(busy), 0);
    chk("R10 go_rd", 32'(go_rd), 0);
    chk("R10 go_wr", 32'(go_wr), 0);
    chk("R10 ready", 32'(issue_ready), 1);

    // single-unit flow, every unit
    for (int u = 0; u < N; u++) begin
      issue(u, '0, '0);
      chk("R1 busy after issue", 32'(busy), 32'(oh(u)));
      step();
      chk("R2 go_rd", 32'(go_rd), 32'(oh(u)));
      chk("R4 no go_wr with go_rd", 32'(go_wr), 0);
      step();
      chk("R2 go_rd single", 32'(go_rd), 0);
      chk("R4 go_wr", 32'(go_wr), 32'(oh(u)));
      wr_done = oh(u);
      step();
      wr_done = '0;
      chk("R8 retire", 32'(busy), 0);
      chk("R4 go_wr single", 32'(go_wr), 0);
    end

    // all ordered producer/consumer pairs
    for (int p = 0; p < N; p++) begin
      for (int c = 0; c < N; c++) begin
        if (c == p) continue;
        issue(p, '0, '0);
        issue(c, oh(p), '0);
        chk("R2 producer go_rd", 32'(go_rd), 32'(oh(p)));
        chk("R1 both busy", 32'(busy), 32'(oh(p) | oh(c)));
        step();
        chk("R3 consumer waits", 32'(go_rd), 0);
        chk("R4 producer go_wr", 32'(go_wr), 32'(oh(p)));
        wr_done = oh(p);
        step();
        wr_done = '0;
        chk("R3 consumer still waits", 32'(go_rd), 0);
        chk("R8 producer retired", 32'(busy), 32'(oh(c)));
        step();
        chk("R3 consumer go_rd", 32'(go_rd), 32'(oh(c)));
        step();
        chk("R6 consumer go_wr", 32'(go_wr), 32'(oh(c)));
        wr_done = oh(c);
        step();
        wr_done = '0;
        chk("R8 consumer retired", 32'(busy), 0);
      end
    end

    // R1 refusal of a busy or dying target
    wr_hold = oh(0);
    issue(0, '0, '0);
    issue_valid = 1'b1;
    issue_unit  = 2'd0;
    issue_raw   = oh(1);
    #1 chk("R1 busy target refused", 32'(issue_ready), 0);
    issue_unit = 2'd2;
    go_die = oh(2);
    #1 chk("R1 dying target refused", 32'(issue_ready), 0);
    go_die = '0;
    issue_valid = 1'b0;
    issue_raw = '0;
    step();
    chk("R1 refused issue no effect", 32'(busy), 32'(oh(0)));
    finish_unit(0);
    step();
    chk("R1 idle after cleanup", 32'(busy), 0);

    // R5 write hold
    wr_hold = oh(2);
    issue(2, '0, '0);
    step();
    chk("R5 go_rd under hold", 32'(go_rd), 32'(oh(2)));
    for (int k = 0; k < 5; k++) begin
      step();
      chk("R5 go_wr held", 32'(go_wr), 0);
    end
    wr_hold = '0;
    step();
    chk("R5 go_wr after release", 32'(go_wr), 32'(oh(2)));
    finish_unit(2);

    // R6 age order
    wr_hold = oh(0);
    issue(0, '0, '0);
    issue(1, '0, '0);
    step();
    chk("R6 younger reads early", 32'(go_rd), 32'(oh(1)));
    for (int k = 0; k < 3; k++) begin
      step();
      chk("R6 younger commit waits", 32'(go_wr), 0);
    end
    wr_hold = '0;
    step();
    chk("R6 older commits", 32'(go_wr), 32'(oh(0)));
    wr_done = oh(0);
    step();
    wr_done = '0;
    chk("R6 younger not same edge", 32'(go_wr), 0);
    step();
    chk("R6 younger commits", 32'(go_wr), 32'(oh(1)));
    finish_unit(1);

    // R7 kill
    wr_hold = oh(0);
    issue(0, '0, '0);
    issue(1, oh(0), '0);
    step();
    go_die = oh(0);
    step();
    go_die = '0;
    wr_hold = '0;
    chk("R7 killed unit idle", 32'(busy), 32'(oh(1)));
    chk("R7 no go_rd yet", 32'(go_rd), 0);
    step();
    chk("R7 dependent released", 32'(go_rd), 32'(oh(1)));
    step();
    chk("R7 no grant for killed", 32'(go_wr), 32'(oh(1)));
    finish_unit(1);

    // R8 early wr_done ignored
    wr_hold = oh(3);
    issue(3, '0, '0);
    wr_done = oh(3);
    step();
    chk("R8 wr_done ignored waiting", 32'(busy), 32'(oh(3)));
    step();
    chk("R8 wr_done ignored exec", 32'(busy), 32'(oh(3)));
    wr_done = '0;
    finish_unit(3);
    chk("R8 retire after commit", 32'(busy), 0);

    // R9 idle and self bits dropped
    issue(2, oh(2) | oh(3), oh(3) | oh(2));
    step();
    chk("R9 go_rd not blocked", 32'(go_rd), 32'(oh(2)));
    step();
    chk("R9 go_wr not blocked", 32'(go_wr), 32'(oh(2)));
    finish_unit(2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule